// File: doc/BRIEF.md
# Tag Memory Access Controller

This block decides, one request at a time, whether an operation on a 34-word contactless tag memory may go ahead. A request names an operation (read a word, write a word, log in, or replace the password), a word address and a received 32-bit password. The block answers with a registered grant or deny verdict one clock later. The memory's own password, protection and control words come in on input buses. Storage, serial framing and bit timing belong to neighbouring blocks.

The block keeps a logged-in flag that one correct login sets and that stays set for every later protected request. Both the power-on reset and the configuration reload clear it. The protection and control words are captured only on the reload strobe. A new configuration written into memory therefore has no effect until the next reload, and a write-inhibited protection word stays locked. The captured read-after-write enable is driven out for the sequencer that follows a write.

Address map: word 0 holds the password and words 1 and 2 hold the protection and control words. Words 3 to 31 are user memory, and words 32 and 33 are factory-fixed identity words that can only be read.

Top module: `tag_access_ctrl`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `resp_valid`, `logged_in` and `raw_en` are 0. The captured protection and control words are all zeros, so afterwards writes to words 3..31 are allowed without login and word 0 is the only read-protected word.
- R2: A request sampled with `req_valid` high gives `resp_valid` high in the next cycle, carrying its verdict on `resp_grant`. Without a request, `resp_valid` is low in the next cycle.
- R3: Login is operation code 2. It is granted, and `logged_in` is set in the next cycle, exactly when `req_pw` equals `stored_pw`. A mismatch is denied and clears `logged_in`.
- R4: A `cfg_load` pulse captures `stored_prot` and `stored_ctrl` and clears `logged_in` in the next cycle. Changes on those two buses at any other time do not affect any verdict.
- R5: A read is operation code 0. A read of word 0 is always denied, a read of any address above 33 is always denied, and words 32 and 33 can be read without login.
- R6: The read-protected range runs inclusively from protection bits 7:0 (first word) to bits 15:8 (last word). A read inside it is granted only when logged in. When first > last the range is empty.
- R7: A write is operation code 1. A write to word 0 or to any address of 32 or above is always denied.
- R8: The write-inhibited range runs inclusively from protection bits 23:16 (first word) to bits 31:24 (last word). A write inside it is denied even when logged in.
- R9: A write to word 1 or 2 that is not inhibited is granted only when logged in.
- R10: A write to words 3..31 that is not inhibited is granted freely when control bit 16 (password check) is 0. When that bit is 1, it is granted only when logged in.
- R11: Password replacement is operation code 3. It is granted exactly when `req_pw` equals `stored_pw`, whatever the address or login state, and it leaves `logged_in` unchanged.
- R12: `raw_en` equals bit 17 of the control word captured at the last `cfg_load` (0 after reset).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| cfg_load | input | 1 | Reload strobe: capture protection and control words and log out |
| req_valid | input | 1 | A request is presented this cycle |
| req_op | input | 2 | 0 read, 1 write, 2 login, 3 password replace |
| req_addr | input | 8 | Target word address |
| req_pw | input | 32 | Password received with the request |
| stored_pw | input | 32 | Password word currently held in memory |
| stored_prot | input | 32 | Protection word currently held in memory |
| stored_ctrl | input | 32 | Control word currently held in memory |
| resp_valid | output | 1 | Verdict present, one cycle after the request |
| resp_grant | output | 1 | 1 grant, 0 deny |
| logged_in | output | 1 | Login state |
| raw_en | output | 1 | Captured read-after-write enable |

## Verification
The main test is a vector table walked under a fixed configuration. It uses password check on, reads protected over words 5..7 and writes inhibited over words 2..4. It probes each address class both before and after login, so the table separates "protected" from "inhibited" and "logged in" from "password check off". The range edges 5 and 7, and addresses 32, 33 and 34, locate the ends of each window. Failed, then correct, then failed logins show the flag being set and cleared. Directed steps then reload a configuration with password check off and an empty read range (first above last). They also change the protection bus without a reload, which must have no effect, and apply a reset, which must fall back to all-zero guards.

// File: rtl/tag_access_pkg.sv
package tag_access_pkg;

    localparam int ADDR_W    = 8;
    localparam int WORD_W    = 32;
    localparam int PW_WORD   = 0;
    localparam int CFG_LAST  = 2;
    localparam int USER_LAST = 31;
    localparam int ROM_LAST  = 33;
    localparam int PWCHK_BIT = 16;
    localparam int RAW_BIT   = 17;

    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_WRITE = 2'd1,
        OP_LOGIN = 2'd2,
        OP_SETPW = 2'd3
    } op_e;

    typedef enum logic [2:0] {
        AC_PASSWORD,
        AC_CONFIG,
        AC_USER,
        AC_ROM,
        AC_INVALID
    } addr_class_e;

    // Field order follows the protection word bit layout (31:0).
    typedef struct packed {
        logic [ADDR_W-1:0] wi_last;
        logic [ADDR_W-1:0] wi_first;
        logic [ADDR_W-1:0] rp_last;
        logic [ADDR_W-1:0] rp_first;
    } guard_t;

    function automatic addr_class_e classify(input logic [ADDR_W-1:0] a);
        if (a == ADDR_W'(PW_WORD))        return AC_PASSWORD;
        else if (a <= ADDR_W'(CFG_LAST))  return AC_CONFIG;
        else if (a <= ADDR_W'(USER_LAST)) return AC_USER;
        else if (a <= ADDR_W'(ROM_LAST))  return AC_ROM;
        else                              return AC_INVALID;
    endfunction

endpackage

// File: rtl/tag_span_match.sv
module tag_span_match #(
    parameter int W = 8
) (
    input  logic [W-1:0] addr,
    input  logic [W-1:0] lo,
    input  logic [W-1:0] hi,
    output logic         hit
);
    // Inclusive window; lo > hi gives an empty window.
    always_comb hit = (addr >= lo) && (addr <= hi);
endmodule

// File: rtl/tag_cfg_latch.sv
module tag_cfg_latch
    import tag_access_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [WORD_W-1:0] prot_in,
    input  logic [WORD_W-1:0] ctrl_in,
    output guard_t            guard_q,
    output logic              pwchk_q,
    output logic              raw_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            guard_q <= '0;
            pwchk_q <= 1'b0;
            raw_q   <= 1'b0;
        end else if (load) begin
            guard_q <= guard_t'(prot_in);
            pwchk_q <= ctrl_in[PWCHK_BIT];
            raw_q   <= ctrl_in[RAW_BIT];
        end
    end
endmodule

// File: rtl/tag_login_state.sv
module tag_login_state (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic attempt,
    input  logic pw_ok,
    output logic logged_in
);
    always_ff @(posedge clk) begin
        if (rst || clear)  logged_in <= 1'b0;
        else if (attempt)  logged_in <= pw_ok;
    end
endmodule

// File: rtl/tag_verdict.sv
module tag_verdict
    import tag_access_pkg::*;
(
    input  op_e               op,
    input  logic [ADDR_W-1:0] addr,
    input  logic              pw_ok,
    input  logic              logged_in,
    input  logic              pwchk,
    input  logic              rp_hit,
    input  logic              wi_hit,
    output logic              grant
);
    addr_class_e cls;

    always_comb begin
        cls   = classify(addr);
        grant = 1'b0;
        unique case (op)
            OP_READ: begin
                unique case (cls)
                    AC_PASSWORD, AC_INVALID: grant = 1'b0;
                    default:                 grant = !rp_hit || logged_in;
                endcase
            end
            OP_WRITE: begin
                if (wi_hit) grant = 1'b0;
                else begin
                    unique case (cls)
                        AC_CONFIG: grant = logged_in;
                        AC_USER:   grant = !pwchk || logged_in;
                        default:   grant = 1'b0;
                    endcase
                end
            end
            OP_LOGIN: grant = pw_ok;
            OP_SETPW: grant = pw_ok;
            default:  grant = 1'b0;
        endcase
    end
endmodule

// File: rtl/tag_access_ctrl.sv
module tag_access_ctrl
    import tag_access_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_load,
    input  logic              req_valid,
    input  logic [1:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [WORD_W-1:0] req_pw,
    input  logic [WORD_W-1:0] stored_pw,
    input  logic [WORD_W-1:0] stored_prot,
    input  logic [WORD_W-1:0] stored_ctrl,
    output logic              resp_valid,
    output logic              resp_grant,
    output logic              logged_in,
    output logic              raw_en
);
    guard_t guard;
    logic   pwchk;
    logic   pw_ok;
    logic   rp_hit;
    logic   wi_hit;
    logic   grant_c;
    op_e    op;

    assign op    = op_e'(req_op);
    assign pw_ok = (req_pw == stored_pw);

    tag_cfg_latch u_cfg (
        .clk     (clk),
        .rst     (rst),
        .load    (cfg_load),
        .prot_in (stored_prot),
        .ctrl_in (stored_ctrl),
        .guard_q (guard),
        .pwchk_q (pwchk),
        .raw_q   (raw_en)
    );

    tag_span_match #(.W(ADDR_W)) u_rd_span (
        .addr (req_addr),
        .lo   (guard.rp_first),
        .hi   (guard.rp_last),
        .hit  (rp_hit)
    );

    tag_span_match #(.W(ADDR_W)) u_wr_span (
        .addr (req_addr),
        .lo   (guard.wi_first),
        .hi   (guard.wi_last),
        .hit  (wi_hit)
    );

    tag_verdict u_verdict (
        .op        (op),
        .addr      (req_addr),
        .pw_ok     (pw_ok),
        .logged_in (logged_in),
        .pwchk     (pwchk),
        .rp_hit    (rp_hit),
        .wi_hit    (wi_hit),
        .grant     (grant_c)
    );

    tag_login_state u_login (
        .clk       (clk),
        .rst       (rst),
        .clear     (cfg_load),
        .attempt   (req_valid && op == OP_LOGIN),
        .pw_ok     (pw_ok),
        .logged_in (logged_in)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            resp_valid <= 1'b0;
            resp_grant <= 1'b0;
        end else begin
            resp_valid <= req_valid;
            resp_grant <= req_valid && grant_c;
        end
    end
endmodule

// File: rtl/tag_access_chk.sv
module tag_access_chk
    import tag_access_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              cfg_load,
    input logic              req_valid,
    input logic [1:0]        req_op,
    input logic [ADDR_W-1:0] req_addr,
    input logic              resp_valid,
    input logic              resp_grant,
    input logic              logged_in
);
    // R2
    resp_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> resp_valid);

    // R2
    no_spurious_resp_chk: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !resp_valid);

    // R3
    login_flag_tracks_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_op == 2'd2 && !cfg_load) |=> (logged_in == resp_grant));

    // R4
    reload_logs_out_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_load |=> !logged_in);

    // R5
    pw_word_unreadable_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_op == 2'd0 && req_addr == '0) |=> !resp_grant);

    // R7
    write_outside_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_op == 2'd1 && (req_addr == '0 || req_addr >= ADDR_W'(32)))
        |=> !resp_grant);

    // R11
    setpw_keeps_login_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_op == 2'd3 && !cfg_load) |=> $stable(logged_in));
endmodule

bind tag_access_ctrl tag_access_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .cfg_load   (cfg_load),
    .req_valid  (req_valid),
    .req_op     (req_op),
    .req_addr   (req_addr),
    .resp_valid (resp_valid),
    .resp_grant (resp_grant),
    .logged_in  (logged_in)
);

// File: tb/tag_access_ctrl_tb.sv
`timescale 1ns/100ps
module tag_access_ctrl_tb;

    localparam logic [31:0] GOOD_PW = 32'hCAFE_1234;
    localparam logic [31:0] BAD_PW  = 32'hCAFE_1235;
    // read-protect 5..7, write-inhibit 2..4
    localparam logic [31:0] PROT_A  = 32'h0402_0705;
    // password check on, read-after-write on
    localparam logic [31:0] CTRL_A  = 32'h0003_0000;

    // {op[1:0], addr[7:0], good_pw, exp_grant, exp_logged}
    localparam int NV = 27;
    localparam logic [12:0] VEC [0:NV-1] = '{
        {2'd0, 8'd0,  1'b1, 1'b0, 1'b0},  // R5 word 0 unreadable
        {2'd0, 8'd10, 1'b1, 1'b1, 1'b0},  // R6 outside range
        {2'd0, 8'd6,  1'b1, 1'b0, 1'b0},  // R6 protected, no login
        {2'd1, 8'd10, 1'b1, 1'b0, 1'b0},  // R10 check on, no login
        {2'd1, 8'd1,  1'b1, 1'b0, 1'b0},  // R9 no login
        {2'd2, 8'd0,  1'b0, 1'b0, 1'b0},  // R3 bad login
        {2'd3, 8'd0,  1'b0, 1'b0, 1'b0},  // R11 bad password replace
        {2'd2, 8'd0,  1'b1, 1'b1, 1'b1},  // R3 good login
        {2'd0, 8'd6,  1'b1, 1'b1, 1'b1},  // R6 logged in
        {2'd0, 8'd5,  1'b1, 1'b1, 1'b1},  // R6 low edge
        {2'd0, 8'd7,  1'b1, 1'b1, 1'b1},  // R6 high edge
        {2'd1, 8'd10, 1'b1, 1'b1, 1'b1},  // R10 logged in
        {2'd1, 8'd1,  1'b1, 1'b1, 1'b1},  // R9 logged in
        {2'd1, 8'd2,  1'b1, 1'b0, 1'b1},  // R8 inhibited low edge
        {2'd1, 8'd3,  1'b1, 1'b0, 1'b1},  // R8 inhibited
        {2'd1, 8'd4,  1'b1, 1'b0, 1'b1},  // R8 inhibited high edge
        {2'd1, 8'd5,  1'b1, 1'b1, 1'b1},  // R8 just past range
        {2'd1, 8'd32, 1'b1, 1'b0, 1'b1},  // R7 identity word
        {2'd0, 8'd32, 1'b1, 1'b1, 1'b1},  // R5 identity readable
        {2'd0, 8'd33, 1'b1, 1'b1, 1'b1},  // R5 last word
        {2'd0, 8'd34, 1'b1, 1'b0, 1'b1},  // R5 beyond map
        {2'd1, 8'd0,  1'b1, 1'b0, 1'b1},  // R7 password word
        {2'd3, 8'd9,  1'b1, 1'b1, 1'b1},  // R11 good, login kept
        {2'd0, 8'd0,  1'b1, 1'b0, 1'b1},  // R5 still unreadable
        {2'd2, 8'd0,  1'b0, 1'b0, 1'b0},  // R3 bad login clears
        {2'd0, 8'd6,  1'b1, 1'b0, 1'b0},  // R6 protected again
        {2'd0, 8'd8,  1'b1, 1'b1, 1'b0}   // R6 outside range
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_load = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_op = '0;
    logic [7:0]  req_addr = '0;
    logic [31:0] req_pw = '0;
    logic [31:0] stored_pw = GOOD_PW;
    logic [31:0] stored_prot = PROT_A;
    logic [31:0] stored_ctrl = CTRL_A;
    logic        resp_valid, resp_grant, logged_in, raw_en;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    tag_access_ctrl u_dut (
        .clk (clk), .rst (rst), .cfg_load (cfg_load),
        .req_valid (req_valid), .req_op (req_op), .req_addr (req_addr),
        .req_pw (req_pw), .stored_pw (stored_pw), .stored_prot (stored_prot),
        .stored_ctrl (stored_ctrl), .resp_valid (resp_valid),
        .resp_grant (resp_grant), .logged_in (logged_in), .raw_en (raw_en)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic apply(input logic [1:0] op, input logic [7:0] addr, input logic [31:0] pw,
                         input logic eg, input logic el, input string req);
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_addr = addr; req_pw = pw;
        @(negedge clk);
        req_valid = 1'b0;
        check({req, " resp_valid/grant/logged_in"},
              {29'd0, resp_valid, resp_grant, logged_in}, {29'd0, 1'b1, eg, el});
    endtask

    task automatic reload(input logic [31:0] prot, input logic [31:0] ctrl);
        @(negedge clk);
        stored_prot = prot; stored_ctrl = ctrl; cfg_load = 1'b1;
        @(negedge clk);
        cfg_load = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 reset outputs", {29'd0, resp_valid, logged_in, raw_en}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 after reset", {29'd0, resp_valid, logged_in, raw_en}, 32'd0);
        // R1 zero guards: user write free, word 6 readable without login
        apply(2'd1, 8'd3, BAD_PW, 1'b1, 1'b0, "R1 zero guard write");
        apply(2'd0, 8'd6, BAD_PW, 1'b1, 1'b0, "R1 zero guard read");

        reload(PROT_A, CTRL_A);
        check("R12 raw_en captured", {31'd0, raw_en}, 32'd1);
        check("R2 idle no resp", {31'd0, resp_valid}, 32'd0);

        for (int i = 0; i < NV; i++) begin
            apply(VEC[i][12:11], VEC[i][10:3], VEC[i][2] ? GOOD_PW : BAD_PW,
                  VEC[i][1], VEC[i][0], $sformatf("vector %0d", i));
        end

        // R4 reload clears login and picks up new guards
        apply(2'd2, 8'd0, GOOD_PW, 1'b1, 1'b1, "R3 login before reload");
        reload(32'h0000_0809, 32'h0000_0000);
        check("R4 reload logs out", {31'd0, logged_in}, 32'd0);
        check("R12 raw_en cleared", {31'd0, raw_en}, 32'd0);
        apply(2'd1, 8'd10, BAD_PW, 1'b1, 1'b0, "R10 check off free write");
        apply(2'd1, 8'd1,  BAD_PW, 1'b0, 1'b0, "R9 config needs login");
        apply(2'd1, 8'd3,  BAD_PW, 1'b1, 1'b0, "R8 inhibit 0..0 only");
        apply(2'd0, 8'd8,  BAD_PW, 1'b1, 1'b0, "R6 empty range low");
        apply(2'd0, 8'd9,  BAD_PW, 1'b1, 1'b0, "R6 empty range high");

        // R4 bus change without reload ignored
        @(negedge clk);
        stored_prot = 32'hFFFF_FFFF; stored_ctrl = 32'hFFFF_FFFF;
        apply(2'd1, 8'd3, BAD_PW, 1'b1, 1'b0, "R4 unlatched prot ignored");
        check("R4 unlatched ctrl ignored", {31'd0, raw_en}, 32'd0);

        // R1 reset mid-run
        apply(2'd2, 8'd0, GOOD_PW, 1'b1, 1'b1, "R3 login before reset");
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check("R1 reset clears", {29'd0, resp_valid, logged_in, raw_en}, 32'd0);
        rst = 1'b0;
        apply(2'd0, 8'd6, BAD_PW, 1'b1, 1'b0, "R1 guards zero after reset");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule